// File: doc/BRIEF.md
# Six-Slot Address Codeword Matcher

This block is the address-recognition stage of a paging receiver. A controller fills six slots with complete 32-bit address codewords. Each codeword carries its flag bit, address, function bits, check bits and parity, so the stored word is exactly what should arrive over the air. Each codeword the receiver delivers with its valid strobe is compared against all six slots at once.

One cycle after the strobe, the block reports three things: a hit flag, a one-hot vector of every slot that matched, and the index of the lowest matching slot. It also reports the two function bits of the received word, which select one of four sub-addresses. A system that needs fewer than six addresses fills the spare slots with copies of an address already loaded. A received word with its most significant bit set is a message word and never matches.

A small state machine holds the result. It has three states:

- `ST_IDLE`: no strobe arrived in the previous cycle.
- `ST_HIT`: the previous strobe matched at least one slot.
- `ST_MISS`: the previous strobe matched no slot.

Its transitions are evaluated on every clock edge, from any state:

- `strobe_hit` moves to `ST_HIT`.
- `strobe_miss` moves to `ST_MISS`.
- `no_strobe` moves to `ST_IDLE`.

Top module: `addr_cw_matcher`

## Requirements
- R1: A write with `load_en` high stores `load_word` in slot `load_slot` (slot A = 0 through slot F = 5). A write with `load_slot` of 6 or 7 changes no slot.
- R2: A match requires all 32 bits of `rx_word` to equal the stored slot. A word differing from a slot in any single bit does not match that slot.
- R3: A received word whose bit 31 is 1 never produces a hit, even when a slot holds that exact word.
- R4: `hit` is high for exactly the one cycle that follows a cycle with `rx_valid` high and a match. A cycle without `rx_valid` produces no hit in the next cycle, whatever `rx_word` holds.
- R5: On a hit, bit i of `slot_onehot` is 1 exactly when slot i matched, so slots holding repeated entries are all flagged.
- R6: On a hit, `slot_idx` is the lowest-numbered matching slot.
- R7: On a hit, `func_code` equals {`rx_word`[12], `rx_word`[11]} of the strobed word. These are the 20th and 21st bits counting from the MSB as the first.
- R8: After reset, all outputs are 0 and every slot holds all ones, so no slot can match until it is loaded.
- R9: When a load and a strobe fall in the same cycle, the comparison uses the slot contents from before the load. The new value takes part from the next strobe on.
- R10: When there is no hit, `slot_onehot`, `slot_idx` and `func_code` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_en | input | 1 | Write strobe for the slot table |
| load_slot | input | 3 | Slot number to write |
| load_word | input | 32 | Codeword to store |
| rx_valid | input | 1 | Received-word strobe |
| rx_word | input | 32 | Received codeword |
| hit | output | 1 | Match flag, one cycle after the strobe |
| slot_onehot | output | 6 | Every slot that matched |
| slot_idx | output | 3 | Lowest matching slot |
| func_code | output | 2 | Function bits of the matched word |

## Verification
A wrong state in this block shows at the ports one cycle after the strobe that exposes it. The symptoms are:

- A corrupted slot register shows as a missing hit, or as a wrong bit in `slot_onehot`.
- A state machine stuck in `ST_HIT` shows as `hit` held into a cycle that had no strobe.
- A priority error shows as `slot_idx` pointing at a higher slot than the lowest set bit of `slot_onehot`.

The stimulus therefore places repeated entries and single-bit neighbours of stored words back to back. It also includes a word with bit 31 set that is stored in a slot, so each fault has a cycle in which it must become visible.

// File: rtl/amatch_pkg.sv
package amatch_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HIT  = 2'd1,
        ST_MISS = 2'd2
    } match_state_t;
endpackage

// File: rtl/amatch_table.sv
module amatch_table #(
    parameter int SLOTS = 6,
    parameter int CW_W  = 32,
    parameter int IDX_W = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      wr_slot,
    input  logic [CW_W-1:0]       wr_word,
    output logic [SLOTS*CW_W-1:0] slots_flat
);
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        logic [CW_W-1:0] entry_q;
        logic            sel;

        assign sel = wr_en && (wr_slot == IDX_W'(s));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                entry_q <= '1;
            end else if (sel) begin
                entry_q <= wr_word;
            end
        end

        assign slots_flat[s*CW_W +: CW_W] = entry_q;
    end
endmodule

// File: rtl/amatch_compare.sv
module amatch_compare #(
    parameter int SLOTS = 6,
    parameter int CW_W  = 32,
    parameter int IDX_W = 3
) (
    input  logic [SLOTS*CW_W-1:0] slots_flat,
    input  logic [CW_W-1:0]       word,
    output logic [SLOTS-1:0]      eq_vec,
    output logic [IDX_W-1:0]      low_idx,
    output logic                  any_eq
);
    logic is_addr;
    assign is_addr = ~word[CW_W-1];

    for (genvar s = 0; s < SLOTS; s++) begin : g_cmp
        assign eq_vec[s] = is_addr && (slots_flat[s*CW_W +: CW_W] == word);
    end

    always_comb begin
        low_idx = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (eq_vec[i]) begin
                low_idx = IDX_W'(i);
            end
        end
    end

    assign any_eq = |eq_vec;
endmodule

// File: rtl/addr_cw_matcher.sv
module addr_cw_matcher
    import amatch_pkg::*;
#(
    parameter int SLOTS  = 6,
    parameter int CW_W   = 32,
    parameter int FN_POS = 20,
    parameter int IDX_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic [IDX_W-1:0] load_slot,
    input  logic [CW_W-1:0]  load_word,
    input  logic             rx_valid,
    input  logic [CW_W-1:0]  rx_word,
    output logic             hit,
    output logic [SLOTS-1:0] slot_onehot,
    output logic [IDX_W-1:0] slot_idx,
    output logic [1:0]       func_code
);
    localparam int FN_HI = CW_W - FN_POS;

    logic [SLOTS*CW_W-1:0] slots_flat;
    logic [SLOTS-1:0]      eq_vec;
    logic [IDX_W-1:0]      low_idx;
    logic                  any_eq;

    match_state_t     state_q, state_d;
    logic [SLOTS-1:0] oh_q;
    logic [IDX_W-1:0] idx_q;
    logic [1:0]       fn_q;

    amatch_table #(.SLOTS(SLOTS), .CW_W(CW_W), .IDX_W(IDX_W)) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (load_en),
        .wr_slot    (load_slot),
        .wr_word    (load_word),
        .slots_flat (slots_flat)
    );

    amatch_compare #(.SLOTS(SLOTS), .CW_W(CW_W), .IDX_W(IDX_W)) u_cmp (
        .slots_flat (slots_flat),
        .word       (rx_word),
        .eq_vec     (eq_vec),
        .low_idx    (low_idx),
        .any_eq     (any_eq)
    );

    // Transitions: strobe_hit, strobe_miss, no_strobe (from any state).
    always_comb begin
        unique case (state_q)
            ST_IDLE, ST_HIT, ST_MISS: begin
                if (!rx_valid)   state_d = ST_IDLE;
                else if (any_eq) state_d = ST_HIT;
                else             state_d = ST_MISS;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            oh_q    <= '0;
            idx_q   <= '0;
            fn_q    <= '0;
        end else begin
            state_q <= state_d;
            if (rx_valid) begin
                oh_q  <= eq_vec;
                idx_q <= low_idx;
                fn_q  <= rx_word[FN_HI -: 2];
            end
        end
    end

    always_comb begin
        hit         = 1'b0;
        slot_onehot = '0;
        slot_idx    = '0;
        func_code   = '0;
        unique case (state_q)
            ST_HIT: begin
                hit         = 1'b1;
                slot_onehot = oh_q;
                slot_idx    = idx_q;
                func_code   = fn_q;
            end
            ST_IDLE, ST_MISS: ;
            default: ;
        endcase
    end
endmodule

// File: rtl/amatch_chk.sv
module amatch_chk #(
    parameter int SLOTS  = 6,
    parameter int CW_W   = 32,
    parameter int FN_POS = 20,
    parameter int IDX_W  = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rx_valid,
    input logic [CW_W-1:0]  rx_word,
    input logic             hit,
    input logic [SLOTS-1:0] slot_onehot,
    input logic [IDX_W-1:0] slot_idx,
    input logic [1:0]       func_code
);
    localparam int FN_HI = CW_W - FN_POS;

    // R3
    msb_never_hits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rx_valid) && $past(rx_word[CW_W-1])) |-> !hit);

    // R4
    no_strobe_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rx_valid) |-> !hit);

    // R5
    hit_has_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (slot_onehot != '0));

    // R6
    lowest_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (((slot_onehot >> slot_idx) & SLOTS'(1)) == SLOTS'(1)) &&
                ((slot_onehot & ((SLOTS'(1) << slot_idx) - SLOTS'(1))) == '0));

    // R7
    func_from_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (func_code == $past(rx_word[FN_HI -: 2])));

    // R10
    quiet_on_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (slot_onehot == '0 && slot_idx == '0 && func_code == '0));
endmodule

bind addr_cw_matcher amatch_chk #(
    .SLOTS(SLOTS), .CW_W(CW_W), .FN_POS(FN_POS), .IDX_W(IDX_W)
) u_amatch_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_valid    (rx_valid),
    .rx_word     (rx_word),
    .hit         (hit),
    .slot_onehot (slot_onehot),
    .slot_idx    (slot_idx),
    .func_code   (func_code)
);

// File: tb/test_addr_cw_matcher.sv
module test_addr_cw_matcher;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_en = 1'b0;
    logic [2:0]  load_slot = '0;
    logic [31:0] load_word = '0;
    logic        rx_valid = 1'b0;
    logic [31:0] rx_word = '0;
    logic        hit;
    logic [5:0]  slot_onehot;
    logic [2:0]  slot_idx;
    logic [1:0]  func_code;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    addr_cw_matcher i_addr_cw_matcher (
        .clk, .rst_n, .load_en, .load_slot, .load_word,
        .rx_valid, .rx_word, .hit, .slot_onehot, .slot_idx, .func_code
    );

    localparam logic [31:0] CW_A = 32'h1234_5A6B; // func 3
    localparam logic [31:0] CW_B = 32'h0ABC_D3F1; // func 2
    localparam logic [31:0] CW_C = 32'h7000_0000; // func 0
    localparam logic [31:0] CW_E = 32'h2222_0822; // func 1

    typedef struct packed {
        logic [31:0] word;
        logic        e_hit;
        logic [5:0]  e_oh;
        logic [2:0]  e_idx;
        logic [1:0]  e_fn;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{CW_A,               1'b1, 6'b001001, 3'd0, 2'd3},
        '{CW_B,               1'b1, 6'b000010, 3'd1, 2'd2},
        '{CW_C,               1'b1, 6'b000100, 3'd2, 2'd0},
        '{CW_E,               1'b1, 6'b110000, 3'd4, 2'd1},
        '{CW_A ^ 32'h0000_0001, 1'b0, 6'b0, 3'd0, 2'd0},
        '{CW_B ^ 32'h0001_0000, 1'b0, 6'b0, 3'd0, 2'd0},
        '{32'h0000_0000,      1'b0, 6'b0, 3'd0, 2'd0}
    };

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic chk_all(input string req, input logic e_hit, input logic [5:0] e_oh,
                           input logic [2:0] e_idx, input logic [1:0] e_fn);
        chk({req, " hit"}, 32'(hit), 32'(e_hit));
        chk({req, " onehot"}, 32'(slot_onehot), 32'(e_oh));
        chk({req, " idx"}, 32'(slot_idx), 32'(e_idx));
        chk({req, " func"}, 32'(func_code), 32'(e_fn));
    endtask

    task automatic load(input logic [2:0] s, input logic [31:0] w);
        @(negedge clk);
        load_en = 1'b1; load_slot = s; load_word = w;
        @(negedge clk);
        load_en = 1'b0;
    endtask

    // drive strobe at a negedge, result visible at the following negedge
    task automatic strobe(input logic [31:0] w);
        @(negedge clk);
        rx_valid = 1'b1; rx_word = w;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog got=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R8 reset state
        chk_all("R8 reset", 1'b0, 6'b0, 3'd0, 2'd0);
        rst_n = 1'b1;
        strobe(32'h0000_0000);
        chk_all("R8 unloaded slots", 1'b0, 6'b0, 3'd0, 2'd0);
        strobe(32'h7FFF_FFFF);
        chk_all("R8 near-ones word", 1'b0, 6'b0, 3'd0, 2'd0);

        // R1 fill table, with repeats
        load(3'd0, CW_A);
        load(3'd1, CW_B);
        load(3'd2, CW_C);
        load(3'd3, CW_A);
        load(3'd4, CW_E);
        load(3'd5, CW_E);

        // table walk, back to back strobes (R2 R5 R6 R7 R10)
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_word = VECS[v].word;
            @(negedge clk);
            rx_valid = 1'b0;
            chk_all($sformatf("R5 R6 R7 vec%0d", v), VECS[v].e_hit, VECS[v].e_oh,
                    VECS[v].e_idx, VECS[v].e_fn);
        end

        // R4 pulse width and no strobe
        strobe(CW_A);
        chk("R4 pulse", 32'(hit), 32'd1);
        @(negedge clk);
        chk("R4 single cycle", 32'(hit), 32'd0);
        @(negedge clk);
        rx_word = CW_B;
        @(negedge clk);
        chk("R4 word without strobe", 32'(hit), 32'd0);

        // R1 out-of-range slot ignored
        load(3'd6, 32'h0555_0000);
        load(3'd7, 32'h0555_0000);
        strobe(32'h0555_0000);
        chk("R1 slot 6/7 ignored", 32'(hit), 32'd0);
        strobe(CW_E);
        chk_all("R1 slot F intact", 1'b1, 6'b110000, 3'd4, 2'd1);

        // R3 MSB-set word stored yet never matches
        load(3'd2, 32'h9234_5A6B);
        strobe(32'h9234_5A6B);
        chk_all("R3 msb word", 1'b0, 6'b0, 3'd0, 2'd0);

        // R9 load and strobe in the same cycle
        @(negedge clk);
        load_en = 1'b1; load_slot = 3'd2; load_word = 32'h0F0F_1800;
        rx_valid = 1'b1; rx_word = 32'h0F0F_1800;
        @(negedge clk);
        load_en = 1'b0; rx_valid = 1'b0;
        chk("R9 old content used", 32'(hit), 32'd0);
        strobe(32'h0F0F_1800);
        chk_all("R9 new content next", 1'b1, 6'b000100, 3'd2, 2'd3);

        // R6 lowest index after overwriting slot 0
        load(3'd0, CW_C);
        strobe(CW_A);
        chk_all("R6 only slot D", 1'b1, 6'b001000, 3'd3, 2'd3);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule